// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt

This block watches the running calendar time and raises an interrupt when it agrees with a programmed alarm. The time arrives as six BCD bytes: seconds, minutes, hours, date, month and weekday. The alarm arrives as six matching bytes. In each alarm byte, the top bit says whether that field takes part in the compare, and the low seven bits hold the BCD value. The year has no alarm byte. The timekeeping counters and the host bus sit outside the block. The block sees them only through the time bus, the update strobe and the status strobes.

The compare is made once per time-update strobe, so one matching second gives one event. There are two ways to signal an event:

- **Latched mode** sets a status flag and holds the active-low interrupt low until software clears the flag.
- **Pulsed mode** also sets the flag, but drives the interrupt low only until the next tick of a slow strobe. It does this again on every later match.

Software clears the flag by writing zero to it. If auto-clear is enabled, a status read also clears it. Events are blocked while the alarm is disabled or the frequency output is enabled.

Top module: `alm_irq_top`

## Requirements
- R1: After reset `irq_n` is 1 and `alm_flag` is 0.
- R2: Bit 7 of each alarm byte enables that field. An event needs every enabled field's time byte to equal the alarm byte with bit 7 taken as 0. Disabled fields are ignored. Field k sits at bits [8k+7:8k] of both buses: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 weekday.
- R3: When no alarm byte has its enable bit set, no event is ever raised.
- R4: The compare counts only in a cycle where `tick_upd` is 1. A matching time without the strobe raises nothing.
- R5: In latched mode (`int_mode`=0), an event sets `alm_flag` and `irq_n` goes to 0 on the same clock edge. Both hold until the flag is cleared.
- R6: A cycle with `stat_wr`=1 and `stat_wr_val`=0 clears the flag. With `stat_wr_val`=1 the write leaves the flag unchanged.
- R7: A cycle with `stat_rd`=1 clears the flag only when `auto_clr`=1. Otherwise the read has no effect.
- R8: In pulsed mode (`int_mode`=1), an event sets the flag and drives `irq_n` to 0. `irq_n` returns to 1 on the first edge at which `slow_tick` is 1, and this repeats for every later match.
- R9: While `alm_en`=0 or `fout_en`=1, no event is raised.
- R10: An event and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_upd | input | 1 | Time-update strobe, one cycle per second |
| time_bus | input | 48 | Current BCD time fields |
| alarm_bus | input | 48 | Alarm bytes, bit 7 of each is the field enable |
| alm_en | input | 1 | Alarm function enable |
| int_mode | input | 1 | 0 latched, 1 pulsed |
| fout_en | input | 1 | Frequency output enabled (blocks alarms) |
| auto_clr | input | 1 | Status read clears the flag |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_val | input | 1 | Flag value carried by the write |
| slow_tick | input | 1 | Slow strobe that ends an interrupt pulse |
| alm_flag | output | 1 | Alarm status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a match landing in the same cycle as a flag clear. The bench lines up the update strobe and a zero write on one negative edge. It then checks that the flag and the interrupt both survive.

Pulse end timing is also only visible at the edges. The bench holds `slow_tick` low for several cycles after a pulsed event, then raises it for a single cycle. It samples `irq_n` on both sides of that edge.

// File: rtl/alm_irq_pkg.sv
package alm_irq_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 8;

    typedef struct packed {
        logic flag;
        logic pulse;
    } irq_state_t;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] tval_i,
    input  logic [W-1:0] aval_i,
    output logic         en_o,
    output logic         hit_o
);
    logic [W-1:0] want;

    always_comb begin
        en_o  = aval_i[W-1];
        want  = {1'b0, aval_i[W-2:0]};
        hit_o = en_o && (tval_i == want);
    end
endmodule

// File: rtl/alm_match_eval.sv
module alm_match_eval #(
    parameter int N = alm_irq_pkg::NUM_FIELDS,
    parameter int W = alm_irq_pkg::FIELD_W
) (
    input  logic [N*W-1:0] time_i,
    input  logic [N*W-1:0] alarm_i,
    input  logic           tick_i,
    input  logic           allow_i,
    output logic           evt_o
);
    logic [N-1:0] en_v;
    logic [N-1:0] hit_v;

    for (genvar k = 0; k < N; k++) begin : g_field
        alm_field_cmp #(.W(W)) u_cmp (
            .tval_i (time_i[k*W +: W]),
            .aval_i (alarm_i[k*W +: W]),
            .en_o   (en_v[k]),
            .hit_o  (hit_v[k])
        );
    end

    logic any_en;
    logic all_ok;

    always_comb begin
        any_en = |en_v;
        all_ok = &(hit_v | ~en_v);
        evt_o  = tick_i && allow_i && any_en && all_ok;
    end
endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
    import alm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic int_mode_i,
    input  logic auto_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_val_i,
    input  logic slow_tick_i,
    output logic flag_o,
    output logic irq_n_o
);
    irq_state_t s_d, s_q;
    logic       clr_req;

    always_comb begin
        s_d     = s_q;
        clr_req = (wr_i && !wr_val_i) || (rd_i && auto_clr_i);
        if (clr_req)
            s_d.flag = 1'b0;
        if (evt_i)
            s_d.flag = 1'b1;
        if (s_q.pulse && slow_tick_i)
            s_d.pulse = 1'b0;
        if (evt_i && int_mode_i)
            s_d.pulse = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign flag_o  = s_q.flag;
    assign irq_n_o = int_mode_i ? !s_q.pulse : !s_q.flag;

    // R5 R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> s_q.flag);

    // R4
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(evt_i));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr_req) |=> s_q.flag);

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pulse && slow_tick_i && !evt_i) |=> !s_q.pulse);

    // R8
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pulse) |-> $past(evt_i && int_mode_i));
endmodule

// File: rtl/alm_irq_top.sv
module alm_irq_top #(
    parameter int N = alm_irq_pkg::NUM_FIELDS,
    parameter int W = alm_irq_pkg::FIELD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_upd,
    input  logic [N*W-1:0] time_bus,
    input  logic [N*W-1:0] alarm_bus,
    input  logic           alm_en,
    input  logic           int_mode,
    input  logic           fout_en,
    input  logic           auto_clr,
    input  logic           stat_rd,
    input  logic           stat_wr,
    input  logic           stat_wr_val,
    input  logic           slow_tick,
    output logic           alm_flag,
    output logic           irq_n
);
    logic allow;
    logic evt;

    assign allow = alm_en && !fout_en;

    alm_match_eval #(.N(N), .W(W)) u_eval (
        .time_i  (time_bus),
        .alarm_i (alarm_bus),
        .tick_i  (tick_upd),
        .allow_i (allow),
        .evt_o   (evt)
    );

    alm_irq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .int_mode_i  (int_mode),
        .auto_clr_i  (auto_clr),
        .rd_i        (stat_rd),
        .wr_i        (stat_wr),
        .wr_val_i    (stat_wr_val),
        .slow_tick_i (slow_tick),
        .flag_o      (alm_flag),
        .irq_n_o     (irq_n)
    );

    // R9
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en || fout_en) |-> !evt);
endmodule

// File: tb/alm_irq_top_bench.sv
module alm_irq_top_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_upd = 0;
    logic [47:0] time_bus = '0;
    logic [47:0] alarm_bus = '0;
    logic        alm_en = 0, int_mode = 0, fout_en = 0, auto_clr = 0;
    logic        stat_rd = 0, stat_wr = 0, stat_wr_val = 0, slow_tick = 0;
    logic        alm_flag, irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alm_irq_top u_alm_irq_top (
        .clk(clk), .rst_n(rst_n), .tick_upd(tick_upd), .time_bus(time_bus),
        .alarm_bus(alarm_bus), .alm_en(alm_en), .int_mode(int_mode),
        .fout_en(fout_en), .auto_clr(auto_clr), .stat_rd(stat_rd),
        .stat_wr(stat_wr), .stat_wr_val(stat_wr_val), .slow_tick(slow_tick),
        .alm_flag(alm_flag), .irq_n(irq_n)
    );

    function automatic logic [47:0] pk(input logic [7:0] s, mi, h, d, mo, w);
        return {w, mo, d, h, mi, s};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one update strobe; returns at the next negedge
    task automatic strobe();
        tick_upd = 1;
        @(negedge clk);
        tick_upd = 0;
    endtask

    task automatic clear_flag();
        stat_wr = 1; stat_wr_val = 0;
        @(negedge clk);
        stat_wr = 0;
    endtask

    task automatic t_reset();
        check("R1 irq_n", irq_n, 1);
        check("R1 flag", alm_flag, 0);
    endtask

    task automatic t_fields();
        alm_en = 1; int_mode = 0;
        time_bus  = pk(8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h03);
        // only minutes and hours enabled; seconds value differs
        alarm_bus = pk(8'h45, 8'h95, 8'h89, 8'h11, 8'h01, 8'h05);
        strobe();
        check("R2 partial match flag", alm_flag, 1);
        check("R5 latched irq", irq_n, 0);
        clear_flag();
        alarm_bus = pk(8'h45, 8'h96, 8'h89, 8'h11, 8'h01, 8'h05);
        strobe();
        check("R2 enabled mismatch", alm_flag, 0);
        alarm_bus = pk(8'hB0, 8'h95, 8'h89, 8'hA1, 8'h86, 8'h83);
        strobe();
        check("R2 all fields match", alm_flag, 1);
        clear_flag();
    endtask

    task automatic t_none_en();
        alarm_bus = pk(8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h03);
        strobe();
        check("R3 no enables", alm_flag, 0);
        check("R3 irq", irq_n, 1);
    endtask

    task automatic t_strobe_only();
        alarm_bus = pk(8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        check("R4 no strobe", alm_flag, 0);
        strobe();
        check("R4 strobe", alm_flag, 1);
    endtask

    task automatic t_latched_hold();
        repeat (5) @(negedge clk);
        check("R5 hold flag", alm_flag, 1);
        check("R5 hold irq", irq_n, 0);
        stat_wr = 1; stat_wr_val = 1;
        @(negedge clk);
        stat_wr = 0;
        check("R6 write one keeps", alm_flag, 1);
        clear_flag();
        check("R6 write zero clears", alm_flag, 0);
        check("R6 irq released", irq_n, 1);
    endtask

    task automatic t_read();
        strobe();
        auto_clr = 0; stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        check("R7 read no auto", alm_flag, 1);
        auto_clr = 1; stat_rd = 1;
        @(negedge clk);
        stat_rd = 0; auto_clr = 0;
        check("R7 read auto clears", alm_flag, 0);
    endtask

    task automatic t_pulsed();
        int_mode = 1;
        strobe();
        check("R8 pulse low", irq_n, 0);
        check("R8 flag set", alm_flag, 1);
        repeat (3) @(negedge clk);
        check("R8 pulse held", irq_n, 0);
        slow_tick = 1;
        @(negedge clk);
        slow_tick = 0;
        check("R8 pulse ended", irq_n, 1);
        clear_flag();
        strobe();
        check("R8 repeat pulse", irq_n, 0);
        slow_tick = 1;
        @(negedge clk);
        slow_tick = 0;
        check("R8 repeat end", irq_n, 1);
        clear_flag();
        int_mode = 0;
    endtask

    task automatic t_block();
        fout_en = 1;
        strobe();
        check("R9 fout blocks", alm_flag, 0);
        fout_en = 0; alm_en = 0;
        strobe();
        check("R9 disabled blocks", alm_flag, 0);
        alm_en = 1;
    endtask

    task automatic t_collide();
        tick_upd = 1; stat_wr = 1; stat_wr_val = 0;
        @(negedge clk);
        tick_upd = 0; stat_wr = 0;
        check("R10 set beats clear", alm_flag, 1);
        check("R10 irq", irq_n, 0);
        clear_flag();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_none_en();
        t_strobe_only();
        t_latched_hold();
        t_read();
        t_pulsed();
        t_block();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule